// File: doc/BRIEF.md
# Paged Memory Read Sequencer with CRC-16

This block is the memory-command layer of a single-wire slave device. It takes received bytes from a byte-level link and returns transmit bytes on request. It serves two read commands. The first is a paged read of a 128-byte data memory organised as four 32-byte pages. The second is a read of an 8-byte status memory. Both commands take a 16-bit start address, low byte first. The block reads a byte-wide memory model through a space select and an address. The memory model answers in the same cycle.

The paged read opens every page with a redirection byte. This byte is fetched from status location 1 + page. A CRC-16 check word follows it. On the first pass that word covers the command, both address bytes and the redirection byte. On later pages it covers only the redirection byte. The page's data bytes come next, up to the page end, followed by a CRC-16 over those data bytes alone. After the last page the block returns FFh until a link reset. A link reset also cuts any sequence short and returns the block to waiting for a command.

Top module: `mrs_read_seq`

## Requirements
- R1: After opcode A5h and two address bytes (low byte first, then high byte), the first transmitted byte is the redirection byte of the page holding the address (page = address bits 6:5). It is read with mem_space = 1 at mem_addr = 1 + page. Status addresses never exceed 7.
- R2: The CRC-16 uses the reflected polynomial value A001h and starts from zero. Each byte is processed least significant bit first. The word is sent inverted, low byte first. On the first pass, the word after the redirection byte covers A5h, both address bytes and the redirection byte.
- R3: Data bytes follow with mem_space = 0. They run from the start address up to the last byte of its page and are followed by a CRC-16 over that page's data bytes only.
- R4: Every later page sends its redirection byte, then a CRC-16 over that byte alone, then all 32 data bytes, then their CRC-16.
- R5: Once the CRC-16 of page 3 has been sent, every transmit request returns FFh until a link reset. The same holds after the status CRC-16, and straight after an address at or beyond the end of the selected memory.
- R6: Opcode AAh reads status bytes from the start address through location 7. A CRC-16 over AAh, both address bytes and every status byte sent follows them.
- R7: A link_reset pulse at any point abandons the sequence. The next received byte is taken as a new command.
- R8: After an opcode other than A5h or AAh, every received byte is ignored and every transmit request returns FFh, until link_reset.
- R9: tx_valid rises exactly one cycle after each tx_req and at no other time. tx_byte changes only on such a response. A request made while a command or address byte is awaited returns FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_reset | input | 1 | Link reset pulse; ends any sequence |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next transmit byte |
| tx_valid | output | 1 | Response to the previous cycle's tx_req |
| tx_byte | output | 8 | Transmit byte, held between responses |
| mem_space | output | 1 | 0 selects data memory, 1 selects status memory |
| mem_addr | output | 7 | Byte address into the selected memory |
| mem_rdata | input | 8 | Same-cycle read data from the memory model |

## Verification
A received byte takes effect in the cycle after its rx_valid. A transmit byte is registered on the edge that ends its tx_req cycle, so it is due one cycle after the request. The bench holds each request for a single cycle between falling edges. It samples tx_byte and tx_valid at the next falling edge, which is the first point where the registered response is stable. Expected bytes, including every CRC-16 word, are rebuilt in the bench from the command stream and a computed memory image. They are compared in transmit order, so a CRC word that covers the wrong bytes shows up at its own position.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam logic [7:0] OP_PAGED_READ  = 8'hA5;
    localparam logic [7:0] OP_STATUS_READ = 8'hAA;
    localparam logic [7:0] FILL_BYTE      = 8'hFF;

    localparam logic SPACE_DATA   = 1'b0;
    localparam logic SPACE_STATUS = 1'b1;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_ADR_LO,
        ST_ADR_HI,
        ST_REDIR,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_DATA,
        ST_ONES,
        ST_SKIP
    } seq_state_t;

    // one accumulator action per cycle
    typedef struct packed {
        logic       clr;
        logic       upd;
        logic [7:0] din;
    } crc_op_t;

    // reflected CRC-16, polynomial x^16+x^15+x^2+1, LSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/mrs_crc_acc.sv
module mrs_crc_acc
    import mrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  crc_op_t     op,
    output logic [15:0] crc
);

    logic [15:0] seed;

    assign seed = op.clr ? 16'h0000 : crc;

    always_ff @(posedge clk) begin
        if (rst)         crc <= 16'h0000;
        else if (op.upd) crc <= crc16_step(seed, op.din);
        else if (op.clr) crc <= 16'h0000;
    end

endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
    import mrs_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int PAGES      = 4,
    parameter int STAT_BYTES = 8,
    parameter int REDIR_BASE = 1,
    localparam int DATA_BYTES = PAGE_BYTES * PAGES,
    localparam int ADDR_W     = $clog2(DATA_BYTES),
    localparam int PAGE_W     = $clog2(PAGE_BYTES),
    localparam int PG_W       = $clog2(PAGES),
    localparam int STAT_W     = $clog2(STAT_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_reset,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    input  logic [7:0]        mem_rdata,
    input  logic [15:0]       crc,
    output crc_op_t           crc_op,
    output logic [7:0]        tx_next,
    output logic              mem_space,
    output logic [ADDR_W-1:0] mem_addr
);

    seq_state_t  state;
    logic        is_stat;
    logic        first_pass;
    logic        after_redir;
    logic [15:0] addr;

    logic [PG_W-1:0] page;
    logic            page_end;
    logic [15:0]     full_addr;

    assign page      = addr[ADDR_W-1:PAGE_W];
    assign full_addr = {rx_byte, addr[7:0]};
    assign page_end  = is_stat ? (addr[STAT_W-1:0] == {STAT_W{1'b1}})
                               : (addr[PAGE_W-1:0] == {PAGE_W{1'b1}});

    // transmit byte selection and memory addressing
    always_comb begin
        tx_next   = FILL_BYTE;
        mem_space = SPACE_DATA;
        mem_addr  = addr[ADDR_W-1:0];
        case (state)
            ST_REDIR: begin
                mem_space = SPACE_STATUS;
                mem_addr  = ADDR_W'(REDIR_BASE) + ADDR_W'(page);
                tx_next   = mem_rdata;
            end
            ST_DATA: begin
                mem_space = is_stat ? SPACE_STATUS : SPACE_DATA;
                tx_next   = mem_rdata;
            end
            ST_CRC_LO: tx_next = ~crc[7:0];
            ST_CRC_HI: tx_next = ~crc[15:8];
            default: ;
        endcase
        if (link_reset) tx_next = FILL_BYTE;
    end

    // accumulator control
    always_comb begin
        crc_op = '{clr: 1'b0, upd: 1'b0, din: rx_byte};
        if (!link_reset) begin
            case (state)
                ST_CMD: if (rx_valid && (rx_byte == OP_PAGED_READ || rx_byte == OP_STATUS_READ)) begin
                    crc_op.clr = 1'b1;
                    crc_op.upd = 1'b1;
                end
                ST_ADR_LO, ST_ADR_HI: crc_op.upd = rx_valid;
                ST_REDIR: if (tx_req) begin
                    crc_op.upd = 1'b1;
                    crc_op.clr = !first_pass;
                    crc_op.din = mem_rdata;
                end
                ST_DATA: if (tx_req) begin
                    crc_op.upd = 1'b1;
                    crc_op.din = mem_rdata;
                end
                ST_CRC_HI: crc_op.clr = tx_req && after_redir;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || link_reset) begin
            state       <= ST_CMD;
            is_stat     <= 1'b0;
            first_pass  <= 1'b0;
            after_redir <= 1'b0;
            addr        <= 16'h0000;
        end else begin
            case (state)
                ST_CMD: if (rx_valid) begin
                    if (rx_byte == OP_PAGED_READ) begin
                        is_stat <= 1'b0;
                        state   <= ST_ADR_LO;
                    end else if (rx_byte == OP_STATUS_READ) begin
                        is_stat <= 1'b1;
                        state   <= ST_ADR_LO;
                    end else begin
                        state   <= ST_SKIP;
                    end
                end
                ST_ADR_LO: if (rx_valid) begin
                    addr[7:0] <= rx_byte;
                    state     <= ST_ADR_HI;
                end
                ST_ADR_HI: if (rx_valid) begin
                    addr[15:8] <= rx_byte;
                    first_pass <= 1'b1;
                    if (!is_stat && full_addr < 16'(DATA_BYTES))     state <= ST_REDIR;
                    else if (is_stat && full_addr < 16'(STAT_BYTES)) state <= ST_DATA;
                    else                                             state <= ST_ONES;
                end
                ST_REDIR: if (tx_req) begin
                    after_redir <= 1'b1;
                    state       <= ST_CRC_LO;
                end
                ST_CRC_LO: if (tx_req) state <= ST_CRC_HI;
                ST_CRC_HI: if (tx_req) begin
                    if (after_redir) begin
                        state <= ST_DATA;
                    end else if (is_stat || addr >= 16'(DATA_BYTES)) begin
                        state <= ST_ONES;
                    end else begin
                        first_pass <= 1'b0;
                        state      <= ST_REDIR;
                    end
                end
                ST_DATA: if (tx_req) begin
                    addr <= addr + 16'd1;
                    if (page_end) begin
                        after_redir <= 1'b0;
                        state       <= ST_CRC_LO;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mrs_read_seq.sv
module mrs_read_seq
    import mrs_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    parameter int PAGES      = 4,
    parameter int STAT_BYTES = 8,
    parameter int REDIR_BASE = 1,
    localparam int ADDR_W    = $clog2(PAGE_BYTES * PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_reset,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);

    crc_op_t     crc_op;
    logic [15:0] crc;
    logic [7:0]  tx_next;

    mrs_crc_acc u_crc (
        .clk (clk),
        .rst (rst),
        .op  (crc_op),
        .crc (crc)
    );

    mrs_ctrl #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGES      (PAGES),
        .STAT_BYTES (STAT_BYTES),
        .REDIR_BASE (REDIR_BASE)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .link_reset (link_reset),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .tx_req     (tx_req),
        .mem_rdata  (mem_rdata),
        .crc        (crc),
        .crc_op     (crc_op),
        .tx_next    (tx_next),
        .mem_space  (mem_space),
        .mem_addr   (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_byte  <= FILL_BYTE;
        end else begin
            tx_valid <= tx_req;
            if (tx_req) tx_byte <= tx_next;
        end
    end

endmodule

// File: rtl/mrs_read_seq_chk.sv
module mrs_read_seq_chk #(
    parameter int ADDR_W     = 7,
    parameter int STAT_BYTES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              link_reset,
    input logic              tx_req,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              mem_space,
    input logic [ADDR_W-1:0] mem_addr
);

    a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> tx_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !tx_req |=> !tx_valid);

    a_r9_byte_holds: assert property (@(posedge clk) disable iff (rst)
        !tx_req |=> $stable(tx_byte));

    a_r7_reset_gives_fill: assert property (@(posedge clk) disable iff (rst)
        link_reset ##1 tx_req |=> tx_byte == 8'hFF);

    a_r1_status_window: assert property (@(posedge clk) disable iff (rst)
        mem_space |-> (mem_addr < ADDR_W'(STAT_BYTES)));

endmodule

bind mrs_read_seq mrs_read_seq_chk #(.ADDR_W(ADDR_W), .STAT_BYTES(STAT_BYTES)) u_chk (.*);

// File: tb/mrs_read_seq_test.sv
`timescale 1ns/1ps
module mrs_read_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       mem_space;
    logic [6:0] mem_addr;
    logic [7:0] mem_rdata;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mrs_read_seq uut (
        .clk(clk), .rst(rst), .link_reset(link_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .mem_space(mem_space), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] data_fn(input int a);
        return 8'((a * 13) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] stat_fn(input int a);
        return 8'(8'hC0 + a * 3);
    endfunction

    always_comb mem_rdata = mem_space ? stat_fn(int'(mem_addr[2:0])) : data_fn(int'(mem_addr));

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] v;
        logic fb;
        v = c;
        for (int i = 0; i < 8; i++) begin
            fb = v[0] ^ d[i];
            v = {1'b0, v[15:1]};
            if (fb) v = v ^ 16'hA001;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual %04h expected %04h", req, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pull_check(input string req, input logic [7:0] exp);
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        check({req, " valid"}, {15'd0, tx_valid}, 16'd1);
        check(req, {8'd0, tx_byte}, {8'd0, exp});
    endtask

    task automatic pulse_link_reset();
        @(negedge clk);
        link_reset = 1'b1;
        @(negedge clk);
        link_reset = 1'b0;
    endtask

    task automatic run_paged(input int start, input int fills);
        int a;
        bit first;
        logic [15:0] c;
        logic [7:0] r;
        push(8'hA5);
        push(8'(start));
        push(8'(start >> 8));
        a = start;
        first = 1;
        c = bcrc(16'h0000, 8'hA5);
        c = bcrc(c, 8'(start));
        c = bcrc(c, 8'(start >> 8));
        while (a < 128) begin
            r = stat_fn(1 + a / 32);
            if (!first) c = 16'h0000;
            c = bcrc(c, r);
            pull_check("R1 redirection byte", r);
            pull_check(first ? "R2 first-pass crc lo" : "R4 later-pass crc lo", ~c[7:0]);
            pull_check(first ? "R2 first-pass crc hi" : "R4 later-pass crc hi", ~c[15:8]);
            c = 16'h0000;
            do begin
                pull_check(first ? "R3 data byte" : "R4 data byte", data_fn(a));
                c = bcrc(c, data_fn(a));
                a++;
            end while (a % 32 != 0);
            pull_check("R3 page crc lo", ~c[7:0]);
            pull_check("R3 page crc hi", ~c[15:8]);
            first = 0;
        end
        for (int k = 0; k < fills; k++) pull_check("R5 fill after last page", 8'hFF);
        pulse_link_reset();
    endtask

    task automatic t_reset_state();
        check("R9 reset tx_valid", {15'd0, tx_valid}, 16'd0);
        check("R9 reset tx_byte", {8'd0, tx_byte}, 16'h00FF);
        pull_check("R9 request while idle", 8'hFF);
    endtask

    task automatic t_status(input int start);
        logic [15:0] c;
        push(8'hAA);
        push(8'(start));
        push(8'h00);
        c = bcrc(bcrc(bcrc(16'h0000, 8'hAA), 8'(start)), 8'h00);
        for (int a = start; a < 8; a++) begin
            pull_check("R6 status byte", stat_fn(a));
            c = bcrc(c, stat_fn(a));
        end
        pull_check("R6 status crc lo", ~c[7:0]);
        pull_check("R6 status crc hi", ~c[15:8]);
        pull_check("R5 fill after status", 8'hFF);
        pulse_link_reset();
    endtask

    task automatic t_abort();
        push(8'hA5);
        push(8'h10);
        pull_check("R9 request during address", 8'hFF);
        push(8'h00);
        pull_check("R1 redirection before abort", stat_fn(1));
        pull_check("R2 crc lo before abort",
            ~bcrc(bcrc(bcrc(bcrc(16'h0, 8'hA5), 8'h10), 8'h00), stat_fn(1))[7:0]);
        pulse_link_reset();
        pull_check("R7 fill right after link reset", 8'hFF);
        t_status(6);
    endtask

    task automatic t_bad_opcode();
        push(8'h33);
        push(8'hA5);
        push(8'h00);
        push(8'h00);
        pull_check("R8 ignored after bad opcode", 8'hFF);
        pull_check("R8 still ignored", 8'hFF);
        pulse_link_reset();
        t_status(7);
    endtask

    task automatic t_out_of_range();
        push(8'hA5);
        push(8'h80);
        push(8'h00);
        pull_check("R5 fill for data address out of range", 8'hFF);
        pulse_link_reset();
        push(8'hAA);
        push(8'h08);
        push(8'h00);
        pull_check("R5 fill for status address out of range", 8'hFF);
        pulse_link_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        run_paged(16'h0000, 3);
        run_paged(16'h0045, 2);
        t_status(2);
        t_abort();
        t_bad_opcode();
        t_out_of_range();
        run_paged(16'h007F, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule